// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides an unsigned 2N-bit dividend by an unsigned N-bit divisor over several clock cycles, producing an N-bit quotient and an N-bit remainder. A one-cycle start pulse captures both operands. The divisor is placed in the upper half of a double-width divisor register, and that register moves one place to the right every round. Each round subtracts the divisor register from a combined remainder register. If the difference is negative, the round adds the divisor back to restore the remainder, and a quotient register takes in one new bit from the right.

The run has N+1 rounds. The first round tests the dividend against the divisor shifted up by N places. That test decides whether the true quotient fits in N bits, so the same round also drives the overflow flag. A zero divisor skips the rounds completely and reports its own flag. When the run ends, a done pulse lasting one cycle marks the results, and the results then stay unchanged until the next accepted start.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held and after it is released, `done`, `quotient`, `remainder`, `overflow` and `div_by_zero` are all 0.
- R2: For a nonzero divisor with dividend < divisor·2^N, at `done` the `quotient` equals floor(dividend / divisor) and the `remainder` equals dividend mod divisor.
- R3: For a nonzero divisor, `overflow` is 1 at `done` exactly when dividend ≥ divisor·2^N, and 0 otherwise.
- R4: For a zero divisor, `done` rises one clock edge after the start edge. At that point `quotient` is all ones, `remainder` equals the low N bits of the dividend, `div_by_zero` is 1 and `overflow` is 0.
- R5: For a nonzero divisor, each of the N+1 rounds takes exactly two cycles, a subtract cycle followed by an adjust cycle. `done` is first high in the cycle after the (2N+3)-th rising edge, counting the edge that samples start as the first (11 edges for N=4).
- R6: `done` is high for exactly one cycle per accepted start.
- R7: `start` is ignored whenever the divider is not idle, including the cycle in which `done` is high. Ignoring it means no restart, no change to the running result and no extra `done` pulse.
- R8: While the divider is idle and `start` is low, `quotient`, `remainder`, `overflow` and `div_by_zero` hold their values.
- R9: The operands are captured at the accepted start. Changes on `dividend` or `divisor` after that edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a division; accepted only when idle |
| dividend | input | 2*QUO_W | Unsigned dividend |
| divisor | input | QUO_W | Unsigned divisor |
| done | output | 1 | One-cycle pulse marking valid results |
| quotient | output | QUO_W | Quotient (all ones on a zero divisor) |
| remainder | output | QUO_W | Remainder (low dividend bits on a zero divisor) |
| overflow | output | 1 | True quotient does not fit in QUO_W bits |
| div_by_zero | output | 1 | Divisor was zero |

## Verification
Two kinds of overlap can occur within a single cycle. A new `start` can arrive while a run is still in progress or in the very cycle that `done` is high. The bench provokes this by raising `start` with different operands in the middle of a run and again in the `done` cycle. It then checks that the first result is intact and that no second `done` appears within a full run length. The zero-divisor and overflow conditions can also both hold for the same operands, since any large dividend "overflows" a zero divisor. The bench applies a large dividend with a zero divisor and expects `div_by_zero` high and `overflow` low.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    // Controller phases of one division run
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUB  = 2'd1,
        ST_ADJ  = 2'd2,
        ST_DONE = 2'd3
    } rdiv_state_e;

    // Operation selected on the shared adder/subtractor
    typedef enum logic {
        ALU_SUB = 1'b0,
        ALU_ADD = 1'b1
    } alu_op_e;

    // Per-cycle commands from the controller to the datapath
    typedef struct packed {
        logic load;   // capture operands, clear quotient
        logic sub;    // remainder <= remainder - divisor register
        logic adj;    // restore if negative, shift quotient and divisor
    } rdiv_ctl_t;

    // Width of the round counter for a quotient of qw bits (counts 0..qw)
    function automatic int rdiv_cnt_width(input int qw);
        return $clog2(qw + 1) + 1;
    endfunction

endpackage

// File: rtl/rdiv_addsub.sv
module rdiv_addsub
    import rdiv_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        if (op == ALU_ADD) begin
            y = a + b;
        end else begin
            y = a - b;
        end
    end

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int QUO_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        divisor_zero,
    output rdiv_ctl_t   ctl,
    output rdiv_state_e state,
    output logic        done
);

    localparam int CW = rdiv_cnt_width(QUO_W);
    localparam logic [CW-1:0] LAST_ROUND = CW'(QUO_W);

    rdiv_state_e state_q, state_d;
    logic [CW-1:0] round_q;
    logic          last_round;

    assign last_round = (round_q == LAST_ROUND);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = divisor_zero ? ST_DONE : ST_SUB;
                end
            end
            ST_SUB:  state_d = ST_ADJ;
            ST_ADJ:  state_d = last_round ? ST_DONE : ST_SUB;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            round_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                round_q <= '0;
            end else if (state_q == ST_ADJ) begin
                round_q <= round_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctl.load = (state_q == ST_IDLE) && start;
        ctl.sub  = (state_q == ST_SUB);
        ctl.adj  = (state_q == ST_ADJ);
    end

    assign state = state_q;
    assign done  = (state_q == ST_DONE);

endmodule

// File: rtl/rdiv_dpath.sv
module rdiv_dpath
    import rdiv_pkg::*;
#(
    parameter int QUO_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rdiv_ctl_t            ctl,
    input  logic [2*QUO_W-1:0]   dividend,
    input  logic [QUO_W-1:0]     divisor,
    output logic                 divisor_zero,
    output logic [QUO_W-1:0]     quotient,
    output logic [QUO_W-1:0]     remainder,
    output logic                 overflow,
    output logic                 div_by_zero
);

    // One guard bit above the 2N-bit span carries the sign of the difference
    localparam int RW = 2 * QUO_W + 1;
    // Quotient keeps N+1 bits; the top one comes from the first round
    localparam int QW = QUO_W + 1;

    logic [RW-1:0] rem_q;
    logic [RW-1:0] dvs_q;
    logic [QW-1:0] quo_q;
    logic          dbz_q;
    logic [RW-1:0] alu_y;
    logic          diff_neg;
    alu_op_e       alu_op;

    assign divisor_zero = (divisor == '0);
    assign diff_neg     = rem_q[RW-1];
    assign alu_op       = ctl.adj ? ALU_ADD : ALU_SUB;

    rdiv_addsub #(.W(RW)) u_alu (
        .a  (rem_q),
        .b  (dvs_q),
        .op (alu_op),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
            dbz_q <= 1'b0;
        end else if (ctl.load) begin
            rem_q <= {1'b0, dividend};
            dvs_q <= {1'b0, divisor, {QUO_W{1'b0}}};
            dbz_q <= divisor_zero;
            quo_q <= divisor_zero ? '1 : '0;
        end else if (ctl.sub) begin
            rem_q <= alu_y;
        end else if (ctl.adj) begin
            if (diff_neg) begin
                rem_q <= alu_y;
            end
            quo_q <= {quo_q[QW-2:0], ~diff_neg};
            dvs_q <= dvs_q >> 1;
        end
    end

    assign quotient    = quo_q[QUO_W-1:0];
    assign remainder   = rem_q[QUO_W-1:0];
    assign overflow    = quo_q[QW-1] & ~dbz_q;
    assign div_by_zero = dbz_q;

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import rdiv_pkg::*;
#(
    parameter int QUO_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [2*QUO_W-1:0]   dividend,
    input  logic [QUO_W-1:0]     divisor,
    output logic                 done,
    output logic [QUO_W-1:0]     quotient,
    output logic [QUO_W-1:0]     remainder,
    output logic                 overflow,
    output logic                 div_by_zero
);

    rdiv_ctl_t   ctl;
    rdiv_state_e state;
    logic        divisor_zero;

    rdiv_ctrl #(.QUO_W(QUO_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .divisor_zero (divisor_zero),
        .ctl          (ctl),
        .state        (state),
        .done         (done)
    );

    rdiv_dpath #(.QUO_W(QUO_W)) u_dpath (
        .clk          (clk),
        .rst          (rst),
        .ctl          (ctl),
        .dividend     (dividend),
        .divisor      (divisor),
        .divisor_zero (divisor_zero),
        .quotient     (quotient),
        .remainder    (remainder),
        .overflow     (overflow),
        .div_by_zero  (div_by_zero)
    );

endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk
    import rdiv_pkg::*;
#(
    parameter int QUO_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic [QUO_W-1:0]   quotient,
    input logic [QUO_W-1:0]   remainder,
    input logic               overflow,
    input logic               div_by_zero,
    input rdiv_state_e        state
);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (rst)
        (done && div_by_zero) |-> (quotient == '1 && !overflow));

    assert_round_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUB) |=> (state == ST_ADJ));

    assert_done_ignores_start_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> ($stable(quotient) && $stable(remainder)
                                          && $stable(overflow) && $stable(div_by_zero)));

endmodule

bind restoring_divider restoring_divider_chk #(.QUO_W(QUO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .overflow    (overflow),
    .div_by_zero (div_by_zero),
    .state       (state)
);

// File: tb/restoring_divider_test.sv
module restoring_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int LAT = 2 * N + 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [2*N-1:0] dividend = '0;
    logic [N-1:0]   divisor = '0;
    logic           done;
    logic [N-1:0]   quotient;
    logic [N-1:0]   remainder;
    logic           overflow;
    logic           div_by_zero;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    restoring_divider #(.QUO_W(N)) uut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .overflow    (overflow),
        .div_by_zero (div_by_zero)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pulse start with operands, return at the negedge where done is seen
    task automatic launch(input int a, input int b, output int lat);
        @(negedge clk);
        dividend = (2*N)'(a);
        divisor  = N'(b);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 100) check(1'b0, "launch timeout", lat, LAT);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(quotient == '0, "R1 quotient", int'(quotient), 0);
        check(remainder == '0, "R1 remainder", int'(remainder), 0);
        check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        check(div_by_zero == 1'b0, "R1 div_by_zero", int'(div_by_zero), 0);
    endtask

    task automatic test_latency();
        int lat;
        launch(100, 7, lat);
        check(lat == LAT, "R5 latency", lat, LAT);
        check(quotient == 4'd14 && remainder == 4'd2, "R2 100/7", int'(quotient), 14);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
    endtask

    task automatic test_zero_divisor();
        int lat;
        launch(8'hB7, 0, lat);
        check(lat == 1, "R4 latency", lat, 1);
        check(quotient == 4'hF, "R4 quotient", int'(quotient), 15);
        check(remainder == 4'h7, "R4 remainder", int'(remainder), 7);
        check(div_by_zero == 1'b1, "R4 flag", int'(div_by_zero), 1);
        check(overflow == 1'b0, "R4 overflow low", int'(overflow), 0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle zero", int'(done), 0);
        launch(50, 5, lat);
        check(div_by_zero == 1'b0, "R4 flag clears", int'(div_by_zero), 0);
        check(quotient == 4'd10 && remainder == 4'd0, "R2 50/5", int'(quotient), 10);
    endtask

    task automatic test_overflow_edges();
        int lat;
        launch(255, 1, lat);
        check(overflow == 1'b1, "R3 255/1", int'(overflow), 1);
        launch(240, 15, lat);
        check(overflow == 1'b1, "R3 240/15", int'(overflow), 1);
        launch(239, 15, lat);
        check(overflow == 1'b0, "R3 239/15", int'(overflow), 0);
        check(quotient == 4'd15 && remainder == 4'd14, "R2 239/15", int'(remainder), 14);
        launch(15, 1, lat);
        check(overflow == 1'b0 && quotient == 4'd15, "R3 15/1", int'(quotient), 15);
    endtask

    task automatic test_busy_start();
        int lat;
        @(negedge clk);
        dividend = 8'd200;
        divisor  = 4'd13;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        dividend = 8'd7;      // R9: operand change after capture
        divisor  = 4'd2;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        start = 1'b1;         // R7: start while busy
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        check(lat == LAT, "R7 busy start no restart", lat, LAT);
        check(quotient == 4'd15, "R9 quotient 200/13", int'(quotient), 15);
        check(remainder == 4'd5, "R9 remainder 200/13", int'(remainder), 5);
        start = 1'b1;         // R7: start in the done cycle
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < LAT + 3; i++) begin
            if (done) check(1'b0, "R7 start in done cycle", 1, 0);
            @(negedge clk);
        end
        check(quotient == 4'd15 && remainder == 4'd5, "R7 result kept", int'(quotient), 15);
    endtask

    task automatic test_hold();
        int lat;
        launch(93, 6, lat);
        dividend = 8'hFF;
        divisor  = 4'd0;
        repeat (6) @(negedge clk);
        check(quotient == 4'd15 && remainder == 4'd3, "R8 hold 93/6", int'(remainder), 3);
        check(overflow == 1'b0 && div_by_zero == 1'b0, "R8 flags hold", int'(overflow), 0);
    endtask

    task automatic test_exhaustive();
        int lat;
        for (int a = 0; a < 256; a++) begin
            for (int b = 1; b < 16; b++) begin
                launch(a, b, lat);
                if (a < b * 16) begin
                    check(int'(quotient) == a / b, "R2 quotient", int'(quotient), a / b);
                    check(int'(remainder) == a % b, "R2 remainder", int'(remainder), a % b);
                    check(overflow == 1'b0, "R3 no overflow", int'(overflow), 0);
                end else begin
                    check(overflow == 1'b1, "R3 overflow", int'(overflow), 1);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        test_reset();
        test_latency();
        test_zero_divisor();
        test_overflow_edges();
        test_busy_start();
        test_hold();
        test_exhaustive();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule